// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers fifteen interrupt sources into pending flags, masks them with per-source enable bits and a global enable, and picks one winner by fixed priority. It presents the winner to the CPU as a 16-bit vector address. Four external pins go through edge detectors, and each pin has its own edge polarity. The watchdog and watch-timer events share one request line. A small event register records which of the two fired. The block drives a wake signal whenever an enabled request is pending, so a stopped or sleeping core can resume.

Six byte registers sit on a simple write-strobe bus with a combinational read port. The CPU side works as a handshake. The controller raises a request with a vector, and the CPU answers with a one-cycle acknowledge when it vectors. A separate return pulse ends the service routine. Two more pulses stand for the enable and disable commands.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, the global enable is 0, and `irq_req` and `wake` are 0.
- R2: The registers sit at BASE_ADDR+0 to +5. Enable-high holds priorities 0..6 in bits 0..6 and enable-low holds priorities 7..14 in bits 0..7. Request-high is at +2 and request-low at +3, with the same bit mapping. Edge-select is at +4 in bits 0..3. The timer-event register is at +5. Unused bits and unmapped addresses read 0.
- R3: External pin n sets flag n on the clock edge where a new level is first seen. If edge-select bit n is 1, a 0-to-1 change sets the flag. If it is 0, a 1-to-0 change sets it. The opposite transition does nothing.
- R4: Writing 0 to a request-flag bit clears it, and writing 1 leaves it unchanged. A hardware set event in the same cycle as a clear wins.
- R5: Priority is fixed, with index 0 highest: pins 0..3, serial event 0, serial event 1, serial event 2, timers 0..4, converter, watchdog/watch, interval timer. A request is raised one cycle after the global enable is 1, no request is held, and some flag is both pending and enabled.
- R6: `irq_vec` = VEC_TOP − 2·index. It and `irq_req` stay stable until `irq_ack`, even if a higher-priority source arrives or the global enable drops.
- R7: On `irq_ack` while `irq_req` is high, `irq_req` falls and the global enable clears. The served flag is cleared only for indices 0..3. Other flags stay set until software clears them.
- R8: The global enable clears on acknowledge, else on a disable pulse. Otherwise it is set by an enable or return pulse. A disable wins over a return in the same cycle.
- R9: The watchdog and watch-timer events both set flag 13. They also set bits 0 and 1 of the timer-event register respectively. Writing 0 to a bit of that register clears it, and a same-cycle event wins.
- R10: `wake` is 1 exactly when some flag is both pending and enabled, whatever the global enable.
- R11: No request is raised while the global enable is 0 or while no pending flag is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ext_pin | input | 4 | External interrupt pins |
| ser_ev | input | 3 | Serial events: UART 0, UART 1, serial I/O |
| tmr_ev | input | 5 | Timer compare-match events 0..4 |
| adc_ev | input | 1 | End-of-conversion event |
| wdt_ev | input | 1 | Watchdog match event |
| wt_ev | input | 1 | Watch-timer match event |
| bit_ev | input | 1 | Interval-timer overflow event |
| gie_set | input | 1 | Enable-command pulse |
| gie_clr | input | 1 | Disable-command pulse |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_ack | input | 1 | CPU acknowledge of the held vector |
| irq_req | output | 1 | Interrupt request to CPU |
| irq_vec | output | 16 | Vector address |
| gie | output | 1 | Global enable state |
| wake | output | 1 | Stop/sleep release |

## Verification
The bench builds the block with its defaults: BASE_ADDR 0xEA and VEC_TOP 0xFFE0. Every index therefore maps to a vector between 0xFFE0 and 0xFFC4. Directed phases cover both edge polarities, clearing and setting in the same cycle, a higher-priority arrival while a vector is held, and the shared watchdog line. A long random phase then mixes pins, events, register writes and handshake pulses. In that phase the reference model checks every output and the read port on every clock.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter logic [7:0]  BASE_ADDR = 8'hEA,
  parameter logic [15:0] VEC_TOP   = 16'hFFE0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_we,
  output logic [7:0]  reg_rdata,
  input  logic [3:0]  ext_pin,
  input  logic [2:0]  ser_ev,
  input  logic [4:0]  tmr_ev,
  input  logic        adc_ev,
  input  logic        wdt_ev,
  input  logic        wt_ev,
  input  logic        bit_ev,
  input  logic        gie_set,
  input  logic        gie_clr,
  input  logic        reti,
  input  logic        irq_ack,
  output logic        irq_req,
  output logic [15:0] irq_vec,
  output logic        gie,
  output logic        wake
);
  localparam int NS = 15;
  localparam int NX = 4;
  localparam int NH = 7;
  localparam int IW = $clog2(NS);
  localparam logic [7:0] A_ENH = BASE_ADDR;
  localparam logic [7:0] A_ENL = BASE_ADDR + 8'd1;
  localparam logic [7:0] A_RQH = BASE_ADDR + 8'd2;
  localparam logic [7:0] A_RQL = BASE_ADDR + 8'd3;
  localparam logic [7:0] A_EDG = BASE_ADDR + 8'd4;
  localparam logic [7:0] A_TEV = BASE_ADDR + 8'd5;

  logic [NS-1:0] pend, en, set_ev, keep, ack_clr, cand;
  logic [NX-1:0] edge_rise, pin_q, ext_ev;
  logic [1:0]    tsrc;
  logic          gie_q, req_q, take;
  logic [IW-1:0] idx_q, win;

  wire wr_enh = reg_we && reg_addr == A_ENH;
  wire wr_enl = reg_we && reg_addr == A_ENL;
  wire wr_rqh = reg_we && reg_addr == A_RQH;
  wire wr_rql = reg_we && reg_addr == A_RQL;
  wire wr_edg = reg_we && reg_addr == A_EDG;
  wire wr_tev = reg_we && reg_addr == A_TEV;

  genvar g;
  generate
    for (g = 0; g < NX; g++) begin : g_edge
      assign ext_ev[g] = edge_rise[g] ? (ext_pin[g] & ~pin_q[g]) : (~ext_pin[g] & pin_q[g]);
    end
  endgenerate

  assign set_ev = {bit_ev, wdt_ev | wt_ev, adc_ev, tmr_ev, ser_ev, ext_ev};
  assign cand   = pend & en;
  assign take   = req_q & irq_ack;

  always_comb begin
    keep = '1;
    if (wr_rqh) keep[NH-1:0]  = reg_wdata[NH-1:0];
    if (wr_rql) keep[NS-1:NH] = reg_wdata;
    ack_clr = '0;
    if (take && idx_q < IW'(NX)) ack_clr[idx_q] = 1'b1;
  end

  always_comb begin
    win = '0;
    for (int i = NS - 1; i >= 0; i--)
      if (cand[i]) win = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      en        <= '0;
      edge_rise <= '0;
      pin_q     <= '0;
      tsrc      <= '0;
      gie_q     <= 1'b0;
      req_q     <= 1'b0;
      idx_q     <= '0;
    end else begin
      pend  <= (pend & keep & ~ack_clr) | set_ev;
      pin_q <= ext_pin;
      if (wr_enh) en[NH-1:0]  <= reg_wdata[NH-1:0];
      if (wr_enl) en[NS-1:NH] <= reg_wdata;
      if (wr_edg) edge_rise   <= reg_wdata[NX-1:0];
      tsrc <= (tsrc & (wr_tev ? reg_wdata[1:0] : 2'b11)) | {wt_ev, wdt_ev};
      if (req_q) begin
        if (irq_ack) req_q <= 1'b0;
      end else if (gie_q && |cand) begin
        req_q <= 1'b1;
        idx_q <= win;
      end
      if (take)                gie_q <= 1'b0;
      else if (gie_clr)        gie_q <= 1'b0;
      else if (gie_set || reti) gie_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_ENH:   reg_rdata = {1'b0, en[NH-1:0]};
      A_ENL:   reg_rdata = en[NS-1:NH];
      A_RQH:   reg_rdata = {1'b0, pend[NH-1:0]};
      A_RQL:   reg_rdata = pend[NS-1:NH];
      A_EDG:   reg_rdata = {4'b0, edge_rise};
      A_TEV:   reg_rdata = {6'b0, tsrc};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq_req = req_q;
  assign irq_vec = VEC_TOP - {{(15 - IW){1'b0}}, idx_q, 1'b0};
  assign gie     = gie_q;
  assign wake    = |cand;

  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));
  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack |=> !gie && !irq_req);
  // R11
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && !gie |=> !irq_req);
  // R7
  ext_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && idx_q < IW'(NX) && !set_ev[idx_q] |=> !pend[$past(idx_q)]);
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev != '0 |=> (pend & $past(set_ev)) == $past(set_ev));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0;
  logic reg_we = 0;
  logic [3:0] ext_pin = 0;
  logic [2:0] ser_ev = 0;
  logic [4:0] tmr_ev = 0;
  logic adc_ev = 0, wdt_ev = 0, wt_ev = 0, bit_ev = 0;
  logic gie_set = 0, gie_clr = 0, reti = 0, irq_ack = 0;
  logic [7:0] reg_rdata;
  logic irq_req, gie, wake;
  logic [15:0] irq_vec;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut_i (.*);

  // reference model
  bit [14:0] m_pend, m_en;
  bit [3:0]  m_sel, m_pin;
  bit [1:0]  m_ts;
  bit        m_gie, m_req;
  int        m_idx;

  always @(posedge clk) begin : model
    bit [14:0] ev, np;
    int w;
    bit old_req;
    if (!rst_n) begin
      m_pend = 0; m_en = 0; m_sel = 0; m_pin = 0; m_ts = 0;
      m_gie = 0; m_req = 0; m_idx = 0;
    end else begin
      for (int i = 0; i < 4; i++)
        ev[i] = m_sel[i] ? (ext_pin[i] && !m_pin[i]) : (!ext_pin[i] && m_pin[i]);
      for (int i = 0; i < 3; i++) ev[4 + i] = ser_ev[i];
      for (int i = 0; i < 5; i++) ev[7 + i] = tmr_ev[i];
      ev[12] = adc_ev; ev[13] = wdt_ev || wt_ev; ev[14] = bit_ev;
      np = m_pend;
      if (reg_we && reg_addr == 8'hEC) for (int i = 0; i < 7; i++) if (!reg_wdata[i]) np[i] = 0;
      if (reg_we && reg_addr == 8'hED) for (int i = 0; i < 8; i++) if (!reg_wdata[i]) np[7 + i] = 0;
      if (m_req && irq_ack && m_idx < 4) np[m_idx] = 0;
      np = np | ev;
      w = -1;
      for (int i = 0; i < 15; i++) if (w < 0 && m_pend[i] && m_en[i]) w = i;
      old_req = m_req;
      if (m_req) begin
        if (irq_ack) m_req = 0;
      end else if (m_gie && w >= 0) begin
        m_req = 1; m_idx = w;
      end
      if (old_req && irq_ack) m_gie = 0;
      else if (gie_clr) m_gie = 0;
      else if (gie_set || reti) m_gie = 1;
      if (reg_we && reg_addr == 8'hEA) for (int i = 0; i < 7; i++) m_en[i] = reg_wdata[i];
      if (reg_we && reg_addr == 8'hEB) for (int i = 0; i < 8; i++) m_en[7 + i] = reg_wdata[i];
      if (reg_we && reg_addr == 8'hEE) m_sel = reg_wdata[3:0];
      if (reg_we && reg_addr == 8'hEF) m_ts = m_ts & reg_wdata[1:0];
      m_ts = m_ts | {wt_ev, wdt_ev};
      m_pin = ext_pin;
      m_pend = np;
    end
  end

  function automatic int m_read(input int a);
    int r = 0;
    case (a)
      'hEA: for (int i = 0; i < 7; i++) r += int'(m_en[i]) << i;
      'hEB: for (int i = 0; i < 8; i++) r += int'(m_en[7 + i]) << i;
      'hEC: for (int i = 0; i < 7; i++) r += int'(m_pend[i]) << i;
      'hED: for (int i = 0; i < 8; i++) r += int'(m_pend[7 + i]) << i;
      'hEE: r = int'(m_sel);
      'hEF: r = int'(m_ts);
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R5 irq_req", int'(irq_req), int'(m_req));
      if (m_req) chk("R6 irq_vec", int'(irq_vec), 'hFFE0 - 2 * m_idx);
      chk("R8 gie", int'(gie), int'(m_gie));
      chk("R10 wake", int'(wake), int'((m_pend & m_en) != 0));
      chk("R2 rdata", int'(reg_rdata), m_read(int'(reg_addr)));
    end
  end

  task automatic tick;
    @(negedge clk);
    reg_we = 0; ser_ev = 0; tmr_ev = 0; adc_ev = 0; wdt_ev = 0; wt_ev = 0; bit_ev = 0;
    gie_set = 0; gie_clr = 0; reti = 0; irq_ack = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    tick; reg_addr = a; reg_wdata = d; reg_we = 1;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    tick; reg_addr = a; #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int a = 'hEA; a <= 'hEF; a++) rd(8'(a), 0, "R1 reset reg");
    chk("R1 gie", int'(gie), 0);
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 wake", int'(wake), 0);
    // R2 enables
    wr(8'hEA, 8'hFF); wr(8'hEB, 8'hFF);
    rd(8'hEA, 'h7F, "R2 enable high");
    rd(8'hEB, 'hFF, "R2 enable low");
    rd(8'hF0, 0, "R2 unmapped");
    // R3 edges: pins 0,2 rising, 1,3 falling
    wr(8'hEE, 8'h05);
    rd(8'hEE, 'h05, "R3 edge select");
    tick; ext_pin[0] = 1;
    tick; ext_pin[1] = 1;
    rd(8'hEC, 'h01, "R3 rise on pin0, no event on pin1 rise");
    tick; ext_pin[1] = 0;
    tick; ext_pin[0] = 0;
    rd(8'hEC, 'h03, "R3 pin1 fall, no event on pin0 fall");
    // R4 software clear
    wr(8'hEC, 8'hFE);
    rd(8'hEC, 'h02, "R4 write0 clears, write1 keeps");
    wr(8'hEC, 8'h00); ext_pin[2] = 1;
    rd(8'hEC, 'h04, "R4 set wins over clear");
    // R11 / R10 with gie low
    tick; tick;
    chk("R11 no req while gie low", int'(irq_req), 0);
    chk("R10 wake with gie low", int'(wake), 1);
    // R5 / R6
    tick; gie_set = 1;
    tick; tick; #1;
    chk("R5 req raised", int'(irq_req), 1);
    chk("R6 vec idx2", int'(irq_vec), 'hFFDC);
    tick; ext_pin[0] = 1;
    tick; tick; #1;
    chk("R6 vec held", int'(irq_vec), 'hFFDC);
    tick; irq_ack = 1;
    tick; #1;
    chk("R7 req drops", int'(irq_req), 0);
    chk("R7 gie cleared", int'(gie), 0);
    rd(8'hEC, 'h01, "R7 external flag cleared");
    tick; reti = 1;
    tick; tick; #1;
    chk("R5 highest priority wins", int'(irq_vec), 'hFFE0);
    tick; irq_ack = 1;
    rd(8'hEC, 'h00, "R7 pin0 flag cleared");
    // R9 shared source
    tick; wdt_ev = 1;
    rd(8'hEF, 'h01, "R9 watchdog bit");
    rd(8'hED, 'h40, "R9 shared flag 13");
    tick; wt_ev = 1;
    rd(8'hEF, 'h03, "R9 watch bit");
    wr(8'hEF, 8'h02);
    rd(8'hEF, 'h02, "R9 write0 clears");
    tick; reti = 1;
    tick; tick; #1;
    chk("R9 vector idx13", int'(irq_vec), 'hFFC6);
    tick; irq_ack = 1;
    rd(8'hED, 'h40, "R7 internal flag kept");
    // R8 precedence
    tick; gie_clr = 1; reti = 1;
    tick; #1;
    chk("R8 disable beats return", int'(gie), 0);
    wr(8'hEB, 8'h00);
    tick; #1;
    chk("R10 wake off when disabled", int'(wake), 0);
    // random phase
    for (int c = 0; c < 4000; c++) begin
      tick;
      if ($urandom_range(0, 5) == 0) ext_pin = 4'($urandom);
      if ($urandom_range(0, 9) == 0) ser_ev = 3'($urandom);
      if ($urandom_range(0, 9) == 0) tmr_ev = 5'($urandom);
      adc_ev = ($urandom_range(0, 15) == 0);
      wdt_ev = ($urandom_range(0, 20) == 0);
      wt_ev  = ($urandom_range(0, 20) == 0);
      bit_ev = ($urandom_range(0, 15) == 0);
      reg_addr = 8'($urandom_range('hE9, 'hF0));
      reg_wdata = 8'($urandom);
      reg_we = ($urandom_range(0, 7) == 0);
      irq_ack = irq_req && ($urandom_range(0, 2) == 0);
      reti = !gie && ($urandom_range(0, 3) == 0);
      gie_set = ($urandom_range(0, 19) == 0);
      gie_clr = ($urandom_range(0, 24) == 0);
    end
    tick; tick;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule